// File: doc/BRIEF.md
# Stereo Programmable Sample Delay Line

This block holds back a stereo stream of parallel audio samples by a whole number of sample periods, with a separate delay for each channel. It is used to line audio up with a slower video path. Each time the sample strobe is high, one left and one right word enter the block. Each word is stored in its own circular buffer. The word that entered the chosen number of strobes earlier comes out two clock cycles later.

Configuration arrives as decoded byte writes into eight registers. These are a control byte, four delay bytes, two stored configuration bytes and a commit location. A write sequence can give one start address and then let later bytes land at successive addresses. Each channel can be silenced on its own, and a bypass setting sends the input straight to the output. The format code held in the control byte is not used inside the block. It is only driven out for the serial-port logic that surrounds the block.

Top module: `stereo_delay_line`

## Requirements
- R1: After a synchronous reset, every register reads as zero. Both output samples are zero, `out_valid` is low, and the committed delays are zero.
- R2: Register addresses are 1 = control, 2 = right delay high, 3 = right delay low, 4 = left delay high, 5 = left delay low, 6 = frame byte, 7 = packet length byte and 8 = commit. A write with `reg_first` high goes to `reg_addr`. A write with `reg_first` low goes to the address after the previous write.
- R3: A channel's delay word is {high[4:0], low[7:0]}. Writing the delay bytes has no effect on the audio until any byte is written to address 8. That write moves both pending words into use.
- R4: With a committed delay of d, the output for the n-th strobe (counted from 0 after reset) equals the input of strobe n−d. A delay of 0 returns the same strobe's input. The output appears with `out_valid` high exactly two clock cycles after the strobe.
- R5: The left and right delays act independently of each other.
- R6: Control bit 3 silences the left channel and bit 2 silences the right channel, so the silenced output is zero. The channel's buffer keeps filling, so clearing the bit gives correctly delayed samples at once.
- R7: Control bit 7 (bypass) makes each output equal its own input, whatever the delay. Silencing takes priority over bypass.
- R8: When d is greater than the number of strobes received since reset, the output is zero.
- R9: A delay larger than the buffer depth minus one (1023 by default) acts as that maximum.
- R10: Control bits 1:0 appear on `fmt_code` (00 I2S, 01 right-justified, 10 left-justified). The bytes at addresses 6 and 7 appear on `frame_cfg` and `pktlen_cfg`.
- R11: Writes to address 0 or to addresses 9 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_first | input | 1 | Write goes to reg_addr (otherwise to the next address) |
| reg_addr | input | 4 | Start address of a write sequence |
| reg_wdata | input | 8 | Write data byte |
| smp_valid | input | 1 | Sample strobe, one stereo pair per pulse |
| smp_left | input | 16 | Left input sample |
| smp_right | input | 16 | Right input sample |
| out_valid | output | 1 | Output pair valid |
| out_left | output | 16 | Delayed left sample |
| out_right | output | 16 | Delayed right sample |
| fmt_code | output | 2 | Stored format code |
| frame_cfg | output | 8 | Stored frame byte |
| pktlen_cfg | output | 8 | Stored packet length byte |

## Verification
An output pair is due two rising edges after its strobe: one edge for the RAM read and one for the output register. The bench therefore drives each strobe on a falling edge and compares the outputs at the falling edge after the second rising edge. A register write takes effect at the edge that captures it, so a strobe sent after a commit already uses the new delay. The bench builds each expected sample from a formula of the strobe index, the committed delay, the history available and the control bits. It then compares that value at this fixed point in time.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam logic [3:0] ADR_CTRL   = 4'd1;
  localparam logic [3:0] ADR_R_HI   = 4'd2;
  localparam logic [3:0] ADR_R_LO   = 4'd3;
  localparam logic [3:0] ADR_L_HI   = 4'd4;
  localparam logic [3:0] ADR_L_LO   = 4'd5;
  localparam logic [3:0] ADR_FRAME  = 4'd6;
  localparam logic [3:0] ADR_PKTLEN = 4'd7;
  localparam logic [3:0] ADR_COMMIT = 4'd8;

  localparam int BYPASS_BIT = 7;
  localparam int MUTE_L_BIT = 3;
  localparam int MUTE_R_BIT = 2;
  localparam int NUM_CH     = 2;
endpackage

// File: rtl/sdl_regs.sv
module sdl_regs
  import sdl_pkg::*;
#(
  parameter int DELAY_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_start,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic [7:0]         ctrl_q,
  output logic [7:0]         frame_q,
  output logic [7:0]         pktlen_q,
  output logic [DELAY_W-1:0] act_left,
  output logic [DELAY_W-1:0] act_right
);
  localparam int HI_W = DELAY_W - 8;

  logic [3:0]      ptr_q;
  logic [3:0]      tgt;
  logic [HI_W-1:0] r_hi_q, l_hi_q;
  logic [7:0]      r_lo_q, l_lo_q;

  assign tgt = wr_start ? wr_addr : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      ctrl_q    <= '0;
      frame_q   <= '0;
      pktlen_q  <= '0;
      r_hi_q    <= '0;
      r_lo_q    <= '0;
      l_hi_q    <= '0;
      l_lo_q    <= '0;
      act_left  <= '0;
      act_right <= '0;
    end else if (wr_en) begin
      ptr_q <= tgt + 4'd1;
      case (tgt)
        ADR_CTRL:   ctrl_q   <= wr_data;
        ADR_R_HI:   r_hi_q   <= wr_data[HI_W-1:0];
        ADR_R_LO:   r_lo_q   <= wr_data;
        ADR_L_HI:   l_hi_q   <= wr_data[HI_W-1:0];
        ADR_L_LO:   l_lo_q   <= wr_data;
        ADR_FRAME:  frame_q  <= wr_data;
        ADR_PKTLEN: pktlen_q <= wr_data;
        ADR_COMMIT: begin
          act_right <= {r_hi_q, r_lo_q};
          act_left  <= {l_hi_q, l_lo_q};
        end
        default: ;
      endcase
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && tgt == ADR_COMMIT) |=> ($stable(act_left) && $stable(act_right))); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ptr_q == $past(tgt) + 4'd1)); // R2

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && tgt == ADR_CTRL) |=> $stable(ctrl_q)); // R11
endmodule

// File: rtl/sdl_chan.sv
module sdl_chan #(
  parameter int DATA_W  = 16,
  parameter int DELAY_W = 13,
  parameter int BUF_AW  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  din,
  input  logic [DELAY_W-1:0] delay,
  input  logic               mute,
  input  logic               bypass,
  output logic               out_valid,
  output logic [DATA_W-1:0]  dout
);
  localparam int DEPTH = 1 << BUF_AW;
  localparam logic [DELAY_W-1:0] MAX_D = DELAY_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BUF_AW-1:0] wp_q, rp, eff;
  logic [BUF_AW:0]   fill_q;
  logic [DATA_W-1:0] rd_q, s1_in;
  logic              s1_v, s1_mute, s1_byp, s1_zero, s1_nohist;

  assign eff = (delay > MAX_D) ? BUF_AW'(DEPTH - 1) : delay[BUF_AW-1:0];
  assign rp  = wp_q - eff;

  // RAM: written every strobe, read before write
  always_ff @(posedge clk) begin
    if (in_valid) begin
      mem[wp_q] <= din;
      rd_q      <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q      <= '0;
      fill_q    <= '0;
      s1_v      <= 1'b0;
      s1_in     <= '0;
      s1_mute   <= 1'b0;
      s1_byp    <= 1'b0;
      s1_zero   <= 1'b0;
      s1_nohist <= 1'b0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        wp_q      <= wp_q + 1'b1;
        if (fill_q != (BUF_AW+1)'(DEPTH)) fill_q <= fill_q + 1'b1;
        s1_in     <= din;
        s1_mute   <= mute;
        s1_byp    <= bypass;
        s1_zero   <= (eff == '0);
        s1_nohist <= ({1'b0, eff} > fill_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        if (s1_mute)                dout <= '0;
        else if (s1_byp || s1_zero) dout <= s1_in;
        else if (s1_nohist)         dout <= '0;
        else                        dout <= rd_q;
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)); // R4

  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mute, 2)) |-> (dout == '0)); // R6

  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(bypass, 2) && !$past(mute, 2)) |-> (dout == $past(din, 2))); // R7

  AST_FILL_MONO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fill_q >= $past(fill_q))); // R8
endmodule

// File: rtl/stereo_delay_line.sv
module stereo_delay_line
  import sdl_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DELAY_W = 13,
  parameter int BUF_AW  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_first,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_left,
  input  logic [DATA_W-1:0] smp_right,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic [1:0]        fmt_code,
  output logic [7:0]        frame_cfg,
  output logic [7:0]        pktlen_cfg
);
  logic [7:0]         ctrl;
  logic [DELAY_W-1:0] dly_l, dly_r;
  logic [DELAY_W-1:0] ch_dly  [NUM_CH];
  logic [DATA_W-1:0]  ch_in   [NUM_CH];
  logic [DATA_W-1:0]  ch_out  [NUM_CH];
  logic [NUM_CH-1:0]  ch_mute, ch_vld;

  sdl_regs #(.DELAY_W(DELAY_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .wr_start  (reg_first),
    .wr_addr   (reg_addr),
    .wr_data   (reg_wdata),
    .ctrl_q    (ctrl),
    .frame_q   (frame_cfg),
    .pktlen_q  (pktlen_cfg),
    .act_left  (dly_l),
    .act_right (dly_r)
  );

  assign ch_dly[0]  = dly_l;
  assign ch_dly[1]  = dly_r;
  assign ch_in[0]   = smp_left;
  assign ch_in[1]   = smp_right;
  assign ch_mute[0] = ctrl[MUTE_L_BIT];
  assign ch_mute[1] = ctrl[MUTE_R_BIT];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sdl_chan #(.DATA_W(DATA_W), .DELAY_W(DELAY_W), .BUF_AW(BUF_AW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (smp_valid),
      .din       (ch_in[c]),
      .delay     (ch_dly[c]),
      .mute      (ch_mute[c]),
      .bypass    (ctrl[BYPASS_BIT]),
      .out_valid (ch_vld[c]),
      .dout      (ch_out[c])
    );
  end

  assign out_valid = &ch_vld;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
  assign fmt_code  = ctrl[1:0];
endmodule

// File: tb/stereo_delay_line_tb.sv
`timescale 1ns/1ps
module stereo_delay_line_tb;
  localparam int MAXD = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_first = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic        out_valid;
  logic [15:0] out_left, out_right;
  logic [1:0]  fmt_code;
  logic [7:0]  frame_cfg, pktlen_cfg;

  int n_chk = 0, n_bad = 0;
  int n_smp = 0;
  logic [7:0]  m_ctrl = '0;
  logic [12:0] m_l = '0, m_r = '0;

  always #4 clk = ~clk;

  stereo_delay_line u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_first(reg_first),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .fmt_code(fmt_code),
    .frame_cfg(frame_cfg), .pktlen_cfg(pktlen_cfg)
  );

  // {ctrl, left delay, right delay}; independent delays per channel (R5)
  localparam logic [33:0] VEC [8] = '{
    {8'h00, 13'd3,  13'd5},
    {8'h00, 13'd0,  13'd0},
    {8'h08, 13'd3,  13'd5},
    {8'h00, 13'd3,  13'd5},
    {8'h04, 13'd1,  13'd2},
    {8'h80, 13'd7,  13'd9},
    {8'h0C, 13'd4,  13'd4},
    {8'h88, 13'd2,  13'd6}
  };

  function automatic logic [15:0] f_l(int n);
    return 16'(n * 37 + 4096);
  endfunction
  function automatic logic [15:0] f_r(int n);
    return 16'((n * 91) ^ 23130);
  endfunction

  function automatic logic [15:0] model(bit right, int n, logic [7:0] c, logic [12:0] d);
    int e;
    e = (int'(d) > MAXD) ? MAXD : int'(d);
    if (right ? c[2] : c[3]) return 16'h0;
    if (c[7]) return right ? f_r(n) : f_l(n);
    if (e > n) return 16'h0;
    return right ? f_r(n - e) : f_l(n - e);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(bit first, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_first = first; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_first = 1'b0;
  endtask

  task automatic config_all(logic [7:0] c, logic [12:0] dl, logic [12:0] dr);
    wr(1'b1, 4'd1, c);
    wr(1'b0, 4'd0, {3'b0, dr[12:8]});
    wr(1'b0, 4'd0, dr[7:0]);
    wr(1'b0, 4'd0, {3'b0, dl[12:8]});
    wr(1'b0, 4'd0, dl[7:0]);
    wr(1'b1, 4'd8, 8'h00);
    m_ctrl = c; m_l = dl; m_r = dr;
  endtask

  function automatic string tag_of(bit right, int n, logic [12:0] d);
    int e;
    e = (int'(d) > MAXD) ? MAXD : int'(d);
    if (right ? m_ctrl[2] : m_ctrl[3]) return "R6";
    if (m_ctrl[7]) return "R7";
    if (e > n) return "R8";
    return "R4";
  endfunction

  task automatic send(string force_tag);
    logic [15:0] el, er;
    string tl, tr;
    el = model(1'b0, n_smp, m_ctrl, m_l);
    er = model(1'b1, n_smp, m_ctrl, m_r);
    tl = (force_tag != "") ? force_tag : tag_of(1'b0, n_smp, m_l);
    tr = (force_tag != "") ? force_tag : tag_of(1'b1, n_smp, m_r);
    smp_valid = 1'b1; smp_left = f_l(n_smp); smp_right = f_r(n_smp);
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    chk("R4 valid", {31'b0, out_valid}, 32'd1);
    chk({tl, " left"},  {16'b0, out_left},  {16'b0, el});
    chk({tr, " right"}, {16'b0, out_right}, {16'b0, er});
    n_smp++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'b0, out_valid}, 32'd0);
    chk("R1 left", {16'b0, out_left}, 32'd0);
    chk("R1 fmt", {30'b0, fmt_code}, 32'd0);
    chk("R1 frame", {24'b0, frame_cfg}, 32'd0);
    send("R1");  // committed delay zero after reset: pass-through

    // Vector table walk: R2 burst, R4..R8
    foreach (VEC[i]) begin
      config_all(VEC[i][33:26], VEC[i][25:13], VEC[i][12:0]);
      for (int k = 0; k < 6; k++) send("");
    end

    // R10 format field and stored bytes, R2 increment past delay registers
    config_all(8'h02, 13'd2, 13'd3);
    chk("R10 fmt", {30'b0, fmt_code}, 32'd2);
    wr(1'b1, 4'd6, 8'hA5);
    wr(1'b0, 4'd0, 8'h3C);
    chk("R10 frame", {24'b0, frame_cfg}, 32'hA5);
    chk("R2 pktlen via increment", {24'b0, pktlen_cfg}, 32'h3C);

    // R11 writes outside 1..8 change nothing
    wr(1'b1, 4'd0, 8'hFF);
    wr(1'b1, 4'd9, 8'h81);
    wr(1'b0, 4'd0, 8'h77);
    wr(1'b1, 4'd15, 8'h55);
    chk("R11 fmt", {30'b0, fmt_code}, 32'd2);
    chk("R11 frame", {24'b0, frame_cfg}, 32'hA5);
    chk("R11 pktlen", {24'b0, pktlen_cfg}, 32'h3C);
    send("R11");

    // R3 pending delay bytes unused until commit
    wr(1'b1, 4'd2, 8'h00);
    wr(1'b0, 4'd0, 8'd11);
    wr(1'b0, 4'd0, 8'h00);
    wr(1'b0, 4'd0, 8'd13);
    send("R3");
    send("R3");
    wr(1'b1, 4'd8, 8'h5A);
    m_l = 13'd13; m_r = 13'd11;
    send("R3");
    send("R3");

    // R9 oversize delays clamp to depth-1
    config_all(8'h00, 13'd8191, 13'd1024);
    for (int k = 0; k < 1040; k++) send("R9");

    // R1 mid-run reset clears registers and history
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_ctrl = '0; m_l = '0; m_r = '0; n_smp = 0;
    chk("R1 valid after reset", {31'b0, out_valid}, 32'd0);
    chk("R1 pktlen after reset", {24'b0, pktlen_cfg}, 32'd0);
    config_all(8'h00, 13'd2, 13'd1);
    for (int k = 0; k < 4; k++) send("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule